// File: doc/BRIEF.md
# Byte SPI Master with Queued Transmit and Flagged Receive

This block is a byte-wide SPI master, driven by a CPU through three registers: data, status and clock divider. Software writes a byte to the data register whenever the status shows the transmit side has room. The byte waits in a one-byte holding slot until the shift engine is free. It then moves into the shifter, and the room flag comes back at once. This lets the next byte be queued while the current one is still on the wire. Queued bytes go out back to back with no idle clock between them.

Every finished byte is placed in a one-byte receive slot and raises the receive-full flag. Software treats this flag as the only sign that a transfer has ended, so its polling loop works at any SCK rate. A read of the data register hands back the byte and clears both receive-full and overrun. A byte that finishes while receive-full is still set is dropped. The older byte stays, and the overrun flag latches until the next data read. Chip select is left to software.

Top module: `spi_dbuf_master`

## Requirements
- R1: Out of reset, the status register reads 0x20 (transmit room set, receive-full and overrun clear), and SCK and MOSI are low.
- R2: Register addresses are 0 for data, 1 for status (read only) and 2 for the divider. In status, bit 7 is receive-full, bit 6 is overrun, bit 5 is transmit room, and all other bits read 0.
- R3: A data write made while transmit room is set is accepted, and transmit room reads 0 in the cycle after the write. The byte is sent MSB first in SPI mode 0: MOSI is stable at each rising SCK edge and changes after falling edges.
- R4: Transmit room sets again as soon as the held byte enters the shifter, so a second byte can be written during the first transfer. That second byte follows with one SCK period from the last rising edge of the first byte to its own first rising edge.
- R5: A data write made while transmit room is clear is ignored: no extra byte appears on MOSI, and the held byte is unchanged.
- R6: When a byte's eighth bit has been shifted, receive-full sets and the data register returns the 8 MISO bits sampled on the rising edges, MSB first.
- R7: A read of the data register clears receive-full and overrun together, and the status then reads 0x20 when the engine is idle.
- R8: If a byte finishes while receive-full is set and no data read occurs in that cycle, the new byte is discarded, the stored byte is kept and overrun sets.
- R9: The SCK period is 2*(divider+1) system clocks, and SCK is low whenever the engine is idle.
- R10: The divider register reads back the value last written to it, and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data, valid in the cycle bus_sel is high |
| sck | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bound checker checks a set of rules on every cycle. SCK stays low while the engine is idle, overrun never appears without receive-full, and a data read clears both flags. A finishing byte always leaves receive-full set, and an overrun keeps the stored byte unchanged. A refused write leaves the held byte untouched, and handing a byte to the shifter frees the holding slot. Other properties can only be shown by the bench's scenarios, which run against a serial slave model and a scoreboard of expected MOSI bytes. These are the bit order on the wire, the measured SCK period at several divider settings, the absence of a gap between queued bytes, the byte that is lost on overrun, and the absence of a byte that should have been refused.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_DIV  = 2'd2,
        REG_RSVD = 2'd3
    } reg_sel_e;

    // status flag offsets counted down from the top bit of the data width
    localparam int ST_RXF_OFS = 1;
    localparam int ST_OVR_OFS = 2;
    localparam int ST_TXE_OFS = 3;
endpackage

// File: rtl/spi_dbuf_tick.sv
module spi_dbuf_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= div) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_dbuf_shift.sv
module spi_dbuf_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    output logic          ld_take,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic          done,
    output logic [DW-1:0] rx_data
);
    localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [CNT_W-1:0] bitcnt;
        logic [DW-1:0]    tx_sh;
        logic [DW-1:0]    rx_sh;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   last_bit;

    assign last_bit = (st_q.bitcnt == LAST_BIT);

    always_comb begin
        st_d    = st_q;
        ld_take = 1'b0;
        done    = 1'b0;
        if (!st_q.active) begin
            if (ld_valid) begin
                ld_take     = 1'b1;
                st_d.active = 1'b1;
                st_d.sck    = 1'b0;
                st_d.bitcnt = '0;
                st_d.tx_sh  = ld_data;
            end
        end else if (tick) begin
            if (!st_q.sck) begin
                // rising edge: capture the incoming bit
                st_d.sck   = 1'b1;
                st_d.rx_sh = {st_q.rx_sh[DW-2:0], miso};
            end else begin
                // falling edge: advance, finish or chain the next byte
                st_d.sck = 1'b0;
                if (last_bit) begin
                    done        = 1'b1;
                    st_d.bitcnt = '0;
                    if (ld_valid) begin
                        ld_take    = 1'b1;
                        st_d.tx_sh = ld_data;
                    end else begin
                        st_d.active = 1'b0;
                    end
                end else begin
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                    st_d.tx_sh  = {st_q.tx_sh[DW-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.active;
    assign sck     = st_q.sck;
    assign mosi    = st_q.active ? st_q.tx_sh[DW-1] : 1'b0;
    assign rx_data = st_q.rx_sh;
endmodule

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs
    import spi_dbuf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_data,
    input  logic              tx_take,
    input  logic              rx_done,
    input  logic [DW-1:0]     rx_byte,
    output logic [DIV_W-1:0]  div,
    output logic              rxfull,
    output logic              ovr,
    output logic [DW-1:0]     rxbuf
);
    typedef struct packed {
        logic [DW-1:0]    txbuf;
        logic             txfull;
        logic [DW-1:0]    rxbuf;
        logic             rxfull;
        logic             ovr;
        logic [DIV_W-1:0] div;
    } reg_st_t;

    reg_st_t       st_d, st_q;
    reg_sel_e      sel;
    logic          wr_data, wr_div, rd_data;
    logic [DW-1:0] stat;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_data = bus_sel &&  bus_wr && (sel == REG_DATA);
    assign wr_div  = bus_sel &&  bus_wr && (sel == REG_DIV);
    assign rd_data = bus_sel && !bus_wr && (sel == REG_DATA);

    always_comb begin
        st_d = st_q;
        if (wr_data && !st_q.txfull) begin
            st_d.txbuf  = bus_wdata;
            st_d.txfull = 1'b1;
        end
        if (tx_take) st_d.txfull = 1'b0;
        if (wr_div)  st_d.div = DIV_W'(bus_wdata);
        if (rd_data) begin
            st_d.rxfull = 1'b0;
            st_d.ovr    = 1'b0;
        end
        if (rx_done) begin
            if (st_q.rxfull && !rd_data) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.rxbuf  = rx_byte;
                st_d.rxfull = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat                 = '0;
        stat[DW-ST_RXF_OFS]  = st_q.rxfull;
        stat[DW-ST_OVR_OFS]  = st_q.ovr;
        stat[DW-ST_TXE_OFS]  = !st_q.txfull;
        case (sel)
            REG_DATA: bus_rdata = st_q.rxbuf;
            REG_STAT: bus_rdata = stat;
            REG_DIV:  bus_rdata = DW'(st_q.div);
            default:  bus_rdata = '0;
        endcase
    end

    assign tx_valid = st_q.txfull;
    assign tx_data  = st_q.txbuf;
    assign div      = st_q.div;
    assign rxfull   = st_q.rxfull;
    assign ovr      = st_q.ovr;
    assign rxbuf    = st_q.rxbuf;
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
    import spi_dbuf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    logic             st_txfull;
    logic [DW-1:0]    st_txbuf;
    logic             eng_take, eng_busy, eng_done, eng_tick;
    logic [DW-1:0]    eng_rx;
    logic [DIV_W-1:0] cfg_div;
    logic             st_rxfull, st_ovr;
    logic [DW-1:0]    st_rxbuf;

    spi_dbuf_regs #(.DW(DW), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_valid  (st_txfull),
        .tx_data   (st_txbuf),
        .tx_take   (eng_take),
        .rx_done   (eng_done),
        .rx_byte   (eng_rx),
        .div       (cfg_div),
        .rxfull    (st_rxfull),
        .ovr       (st_ovr),
        .rxbuf     (st_rxbuf)
    );

    spi_dbuf_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (eng_busy),
        .div   (cfg_div),
        .tick  (eng_tick)
    );

    spi_dbuf_shift #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (eng_tick),
        .ld_valid (st_txfull),
        .ld_data  (st_txbuf),
        .ld_take  (eng_take),
        .busy     (eng_busy),
        .sck      (sck),
        .mosi     (mosi),
        .miso     (miso),
        .done     (eng_done),
        .rx_data  (eng_rx)
    );
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk
    import spi_dbuf_pkg::*;
#(
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              sck,
    input logic              eng_busy,
    input logic              eng_done,
    input logic              eng_take,
    input logic              st_txfull,
    input logic [DW-1:0]     st_txbuf,
    input logic              st_rxfull,
    input logic              st_ovr,
    input logic [DW-1:0]     st_rxbuf
);
    logic rd_hit, wr_hit;
    assign rd_hit = bus_sel && !bus_wr && (bus_addr == REG_DATA);
    assign wr_hit = bus_sel &&  bus_wr && (bus_addr == REG_DATA);

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !sck); // R9
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        st_ovr |-> st_rxfull); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && !eng_done |=> !st_rxfull && !st_ovr); // R7
    AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> st_rxfull); // R6
    AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && st_rxfull && !rd_hit |=> st_ovr && $stable(st_rxbuf)); // R8
    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && st_txfull && !eng_take |=> $stable(st_txbuf) && st_txfull); // R5
    AST_TAKE_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_take |=> !st_txfull); // R4
endmodule

bind spi_dbuf_master spi_dbuf_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .sck       (sck),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .eng_take  (eng_take),
    .st_txfull (st_txfull),
    .st_txbuf  (st_txbuf),
    .st_rxfull (st_rxfull),
    .st_ovr    (st_ovr),
    .st_rxbuf  (st_rxbuf)
);

// File: tb/spi_dbuf_master_tb_top.sv
module spi_dbuf_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sck, mosi, miso;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    spi_dbuf_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] resp_of(input int n);
        return 8'((60 + 23 * n) ^ (n << 4));
    endfunction

    // ---------------- slave model and scoreboard monitor ----------------
    logic [7:0] exp_mosi[$];
    int         rise_q[$];
    logic [7:0] slv_in = 8'd0;
    logic [7:0] slv_out;
    int         slv_bit = 0;
    int         slv_n = 0;

    initial slv_out = resp_of(0);
    assign miso = slv_out[7];

    always @(posedge sck) begin
        logic [7:0] got, want;
        rise_q.push_back(cyc);
        got = {slv_in[6:0], mosi};
        slv_in = got;
        if (slv_bit == 7) begin
            slv_bit = 0;
            slv_n++;
            slv_out = resp_of(slv_n);
            if (exp_mosi.size() == 0) begin
                check(1'b0, "R5 unexpected MOSI byte", got, 0);
            end else begin
                want = exp_mosi.pop_front();
                check(got == want, "R3 MOSI byte", got, want);
            end
        end else begin
            slv_bit++;
            slv_out = {slv_out[6:0], 1'b0};
        end
    end

    // ---------------- bus driver (each task starts and ends at a negedge) ----
    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        exp_mosi.push_back(d);
        reg_wr(2'd0, d);
    endtask

    task automatic wait_bit(input int b, input string req);
        logic [7:0] s;
        int n = 0;
        s = 8'd0;
        while (!s[b] && n < 5000) begin
            reg_rd(2'd1, s);
            n++;
        end
        if (!s[b]) check(1'b0, req, s, 1 << b);
    endtask

    task automatic check_periods(input int first, input int last, input int per, input string req);
        for (int i = first; i < last; i++)
            check(rise_q[i+1] - rise_q[i] == per, req, rise_q[i+1] - rise_q[i], per);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 reset state
        reg_rd(2'd1, v);
        check(v == 8'h20, "R1 R2 status after reset", v, 8'h20);
        check(sck == 1'b0 && mosi == 1'b0, "R1 sck/mosi low", {sck, mosi}, 0);
        reg_rd(2'd2, v);
        check(v == 8'h00, "R10 divider reset", v, 0);

        // R10 divider write and readback, then single transfer (R3, R6, R9)
        reg_wr(2'd2, 8'd3);
        reg_rd(2'd2, v);
        check(v == 8'd3, "R10 divider readback", v, 3);
        rise_q.delete();
        send(8'hA5);
        reg_rd(2'd1, v);
        check(v[5] == 1'b0, "R3 room clear after write", v, 8'h00);
        wait_bit(7, "R6 receive-full timeout");
        reg_rd(2'd0, v);
        check(v == resp_of(0), "R6 received byte", v, resp_of(0));
        reg_rd(2'd1, v);
        check(v == 8'h20, "R7 status after read", v, 8'h20);
        check(rise_q.size() == 8, "R9 edge count", rise_q.size(), 8);
        check_periods(0, 7, 8, "R9 period div=3");

        // R4 back-to-back at divider 0
        reg_wr(2'd2, 8'd0);
        rise_q.delete();
        send(8'h3C);
        wait_bit(5, "R4 room returns");
        send(8'hC3);
        reg_rd(2'd1, v);
        check(v[5] == 1'b0, "R4 second byte accepted", v, 8'h00);
        wait_bit(7, "R6 receive-full timeout");
        reg_rd(2'd0, v);
        check(v == resp_of(1), "R6 first queued byte", v, resp_of(1));
        wait_bit(7, "R6 receive-full timeout");
        reg_rd(2'd0, v);
        check(v == resp_of(2), "R6 second queued byte", v, resp_of(2));
        check(rise_q.size() == 16, "R4 edge count", rise_q.size(), 16);
        check(rise_q[8] - rise_q[7] == 2, "R4 no gap", rise_q[8] - rise_q[7], 2);
        check_periods(0, 7, 2, "R9 period div=0");

        // R8 overrun at divider 1
        reg_wr(2'd2, 8'd1);
        rise_q.delete();
        send(8'h81);
        wait_bit(5, "R4 room returns");
        send(8'h7E);
        wait_bit(6, "R8 overrun timeout");
        reg_rd(2'd1, v);
        check(v == 8'hE0, "R8 status on overrun", v, 8'hE0);
        reg_rd(2'd0, v);
        check(v == resp_of(3), "R8 older byte kept", v, resp_of(3));
        reg_rd(2'd1, v);
        check(v == 8'h20, "R7 read clears both flags", v, 8'h20);
        check_periods(0, 7, 4, "R9 period div=1");
        send(8'h5A);
        wait_bit(7, "R6 receive-full timeout");
        reg_rd(2'd0, v);
        check(v == resp_of(5), "R8 normal after overrun", v, resp_of(5));

        // R5 write refused while holding slot is full
        reg_wr(2'd2, 8'd2);
        send(8'h11);
        wait_bit(5, "R4 room returns");
        send(8'h22);
        reg_wr(2'd0, 8'hEE);
        wait_bit(7, "R6 receive-full timeout");
        reg_rd(2'd0, v);
        check(v == resp_of(6), "R6 byte before refused write", v, resp_of(6));
        wait_bit(7, "R6 receive-full timeout");
        reg_rd(2'd0, v);
        check(v == resp_of(7), "R6 byte after refused write", v, resp_of(7));
        repeat (200) @(negedge clk);
        check(slv_n == 8, "R5 no extra byte sent", slv_n, 8);
        reg_rd(2'd1, v);
        check(v == 8'h20, "R5 status idle", v, 8'h20);
        check(sck == 1'b0, "R9 sck idle low", sck, 0);
        check(exp_mosi.size() == 0, "R3 scoreboard drained", exp_mosi.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule